// File: doc/BRIEF.md
# Strict-Priority and Weighted-Fair Transmit Arbiter

This block decides, for one egress port, which client may send its next packet. A client is a management source, one of two debug sources, or a traffic class. Client 3+n carries traffic class n, and clients 0, 1 and 2 are the management and debug sources. The default configuration has nine clients (six traffic classes). Setting `NCLI` to 6 gives the smaller port with three traffic classes.

Every client is served either by strict priority or by weighted-fair sharing. The service order is a table of priority slots, and each slot names one client. Strict clients that are requesting are taken in slot order. When no strict client can be served, the weighted clients that hold non-negative credit compete, again in slot order. Each weighted client has a credit counter. The counter gains the client's weight every cycle, is capped by the client's ceiling, and loses the packet length when the client is granted. A limit on consecutive grants stops one strict client from holding the port.

Software sets the slot table, the two client bitmaps, the weights, the ceilings and the burst limit through a single write port. Each write is one cycle with `cfg_kind`, `cfg_idx` and `cfg_data`.

Top module: `txarb_sp_wfq`

## Requirements
- R1: After reset `grant` is zero. The reset configuration is:
  - slot s holds client s;
  - every client is strict and none is weighted;
  - all weights are 0;
  - every ceiling is max(150*MIN_WEIGHT, MAX_PKT), which is 9600 by default;
  - the burst limit is 256.

  With this configuration the lowest-numbered requesting client wins.
- R2: A decision is made on a clock edge only when `grant` is zero.
  - A decision grants at most one requesting client.
  - The grant is registered and appears one cycle after the request is seen.
  - The grant lasts exactly one cycle, so two grants are always separated by at least one idle cycle.
- R3: Among the strict clients that are requesting and eligible, the one in the lowest slot wins. A write with kind 0 places client `cfg_data` in slot `cfg_idx`.
- R4: Clients 0, 1 and 2 are fixed:
  - slot writes to indices 0 to 2 are ignored;
  - strict bits 0 to 2 stay set whatever kind-1 data is written.
- R5: A requesting, eligible strict client always beats every weighted client, whatever their slot positions.
- R6: A client can win in the weighted phase only if all of the following hold:
  - its bit is set in the weighted bitmap (kind 2, bit i = client i);
  - its strict bit (kind 1) is clear;
  - its credit is non-negative.

  Ties go to the lowest slot. A client that is neither strict nor weighted is never granted.
- R7: Credit is updated every cycle for each weighted client:
  - it becomes min(credit + weight, ceiling) and then drops by the granted packet length (`req_len` field i);
  - it may go negative;
  - weight is set with kind 3 and the ceiling with kind 4;
  - a client outside the weighted bitmap holds credit 0.
- R8: The burst limit is set with kind 5, and a value of 0 acts as 1.
  - A strict client that has received that many consecutive grants is skipped in the next decision.
  - A decision with no grant clears the run.
  - A grant to any other client also clears the run.
- R9: Writes take effect only on edges where `grant` is zero. Writes presented while a grant is showing are discarded, and so are slot writes whose client number is not below `NCLI`.
- R10: The reset ceiling limits credit. With weight 4095, a long wait, and a 16383-byte grant, the next grant of a continuously requesting client comes 3 cycles after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NCLI | Per-client request |
| req_len | input | NCLI*LENW | Per-client packet length, field i at bits i*LENW upward |
| grant | output | NCLI | One-hot, one-cycle grant |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Write target: 0 slot, 1 strict bitmap, 2 weighted bitmap, 3 weight, 4 ceiling, 5 burst limit |
| cfg_idx | input | IDW | Slot or client index for kinds 0, 3 and 4 |
| cfg_data | input | CDW | Write value |

## Verification
The assertions watch, on every cycle, that:
- the grant is one-hot and never lasts two cycles;
- the grant always goes to a client that requested in the decision cycle;
- no credit counter rises above its ceiling;
- the slot table does not move when a write arrives during a grant.

The ordering results need the bench's scenarios. These cover the winner chosen under a reprogrammed slot table, strict service beating weighted service, and the exact cycle in which a client with negative credit becomes eligible again. The bench also shows the burst-limit skip pattern.

// File: rtl/txarb_sp_wfq.sv
module txarb_sp_wfq #(
  parameter int NCLI       = 9,
  parameter int IDW        = 4,
  parameter int LENW       = 14,
  parameter int WTW        = 12,
  parameter int CRW        = 16,
  parameter int BRW        = 9,
  parameter int CDW        = 16,
  parameter int MIN_WEIGHT = 16,
  parameter int MAX_PKT    = 9600,
  parameter int FIXED      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCLI-1:0]      req,
  input  logic [NCLI*LENW-1:0] req_len,
  output logic [NCLI-1:0]      grant,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_kind,
  input  logic [IDW-1:0]       cfg_idx,
  input  logic [CDW-1:0]       cfg_data
);
  localparam int CEILW = CRW - 1;
  localparam int CEIL_RST = (150 * MIN_WEIGHT > MAX_PKT) ? 150 * MIN_WEIGHT : MAX_PKT;
  localparam logic [NCLI-1:0] FIX_MASK = NCLI'((1 << FIXED) - 1);
  localparam logic [BRW-1:0] BURST_RST = BRW'(256);

  logic [IDW-1:0]          slot_q [NCLI];
  logic [NCLI-1:0]         strict_q, wfq_q;
  logic [WTW-1:0]          wt_q   [NCLI];
  logic [CEILW-1:0]        ceil_q [NCLI];
  logic signed [CRW-1:0]   cred_q [NCLI];
  logic [BRW-1:0]          burst_q, streak_q;
  logic [IDW-1:0]          last_q;
  logic                    last_sp_q;
  logic [NCLI*IDW-1:0]     slot_flat;
  logic [NCLI*CRW-1:0]     cred_flat;
  logic [NCLI*CEILW-1:0]   ceil_flat;

  logic decide, wr_ok, idx_ok;
  logic [BRW-1:0] lim;
  assign decide = (grant == '0);
  assign wr_ok  = cfg_we && decide;
  assign idx_ok = cfg_idx < IDW'(NCLI);
  assign lim    = (burst_q == '0) ? BRW'(1) : burst_q;

  logic [NCLI-1:0] sp_hit, wf_hit;
  for (genvar s = 0; s < NCLI; s++) begin : g_slot
    logic [IDW-1:0] c;
    logic held;
    assign c         = slot_q[s];
    assign held      = last_sp_q && (last_q == c) && (streak_q >= lim);
    assign sp_hit[s] = req[c] && strict_q[c] && !held;
    assign wf_hit[s] = req[c] && wfq_q[c] && !strict_q[c] && !cred_q[c][CRW-1];
    assign slot_flat[s*IDW +: IDW] = slot_q[s];
  end

  logic           pick_v, pick_sp;
  logic [IDW-1:0] pick_c;
  always_comb begin
    pick_v = 1'b0; pick_sp = 1'b0; pick_c = '0;
    for (int s = NCLI - 1; s >= 0; s--)
      if (wf_hit[s]) begin pick_v = 1'b1; pick_c = slot_q[s]; end
    for (int s = NCLI - 1; s >= 0; s--)
      if (sp_hit[s]) begin pick_v = 1'b1; pick_c = slot_q[s]; pick_sp = 1'b1; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= '0; streak_q <= '0; last_q <= '0; last_sp_q <= 1'b0;
    end else if (decide) begin
      grant <= pick_v ? (NCLI'(1) << pick_c) : '0;
      if (!pick_v) begin
        streak_q  <= '0;
        last_sp_q <= 1'b0;
      end else begin
        streak_q  <= (pick_sp && last_sp_q && last_q == pick_c) ? streak_q + 1'b1 : BRW'(1);
        last_q    <= pick_c;
        last_sp_q <= pick_sp;
      end
    end else begin
      grant <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NCLI; s++) begin
        slot_q[s] <= IDW'(s);
        wt_q[s]   <= '0;
        ceil_q[s] <= CEILW'(CEIL_RST);
      end
      strict_q <= '1;
      wfq_q    <= '0;
      burst_q  <= BURST_RST;
    end else if (wr_ok) begin
      case (cfg_kind)
        3'd0: if (idx_ok && cfg_idx >= IDW'(FIXED) && cfg_data < CDW'(NCLI))
                slot_q[cfg_idx] <= cfg_data[IDW-1:0];
        3'd1: strict_q <= cfg_data[NCLI-1:0] | FIX_MASK;
        3'd2: wfq_q <= cfg_data[NCLI-1:0];
        3'd3: if (idx_ok) wt_q[cfg_idx] <= cfg_data[WTW-1:0];
        3'd4: if (idx_ok) ceil_q[cfg_idx] <= cfg_data[CEILW-1:0];
        3'd5: burst_q <= cfg_data[BRW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NCLI; i++) begin : g_cli
    logic signed [CRW-1:0] cr;
    logic signed [CRW:0]   sum, capped, nxt, ceil_x;
    logic                  take;
    assign take   = decide && pick_v && (pick_c == IDW'(i));
    assign sum    = $signed({cr[CRW-1], cr}) + $signed({{(CRW + 1 - WTW){1'b0}}, wt_q[i]});
    assign ceil_x = $signed({2'b00, ceil_q[i]});
    assign capped = (sum > ceil_x) ? ceil_x : sum;
    assign nxt    = capped - (take ? $signed({{(CRW + 1 - LENW){1'b0}}, req_len[i*LENW +: LENW]})
                                   : $signed({(CRW + 1){1'b0}}));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cr <= '0;
      else if (!wfq_q[i]) cr <= '0;
      else                cr <= nxt[CRW-1:0];
    end
    assign cred_q[i] = cr;
    assign cred_flat[i*CRW +: CRW]       = cr;
    assign ceil_flat[i*CEILW +: CEILW]   = ceil_q[i];
  end
endmodule

// File: rtl/txarb_sp_wfq_chk.sv
module txarb_sp_wfq_chk #(
  parameter int NCLI = 9,
  parameter int IDW  = 4,
  parameter int CRW  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NCLI-1:0]          req,
  input logic [NCLI-1:0]          grant,
  input logic                     cfg_we,
  input logic [NCLI*IDW-1:0]      slot_flat,
  input logic [NCLI*CRW-1:0]      cred_flat,
  input logic [NCLI*(CRW-1)-1:0]  ceil_flat
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  p_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (grant == '0));

  p_to_requester_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (($past(req) & grant) == grant));

  p_write_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && grant != '0) |=> $stable(slot_flat));

  for (genvar i = 0; i < NCLI; i++) begin : g_cap
    p_credit_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(cred_flat[i*CRW +: CRW]) <= $signed({1'b0, $past(ceil_flat[i*(CRW-1) +: (CRW-1)])}));
  end
endmodule

bind txarb_sp_wfq txarb_sp_wfq_chk #(.NCLI(NCLI), .IDW(IDW), .CRW(CRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .cfg_we(cfg_we),
  .slot_flat(slot_flat), .cred_flat(cred_flat), .ceil_flat(ceil_flat)
);

// File: tb/txarb_sp_wfq_test.sv
`timescale 1ns/1ps
module txarb_sp_wfq_test;
  localparam int N = 9;
  localparam int LW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N*LW-1:0] req_len;
  logic [N-1:0] grant;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_kind = '0;
  logic [3:0] cfg_idx = '0;
  logic [15:0] cfg_data = '0;
  logic [LW-1:0] lens [N];
  int total = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) req_len[i*LW +: LW] = lens[i];

  txarb_sp_wfq uut (.clk(clk), .rst_n(rst_n), .req(req), .req_len(req_len), .grant(grant),
                    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_data(cfg_data));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int idx, input int data);
    cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_idx = 4'(idx); cfg_data = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_req(input string tag, input int m, input int exp);
    req = N'(m);
    @(negedge clk);
    chk(tag, int'(grant), exp);
    req = '0;
    @(negedge clk);
    chk("R2 grant lasts one cycle", int'(grant), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int lowest(input int m);
    for (int i = 0; i < N; i++) if (m[i]) return 1 << i;
    return 0;
  endfunction

  function automatic int rev_exp(input int m);
    if ((m & 7) != 0) return lowest(m);
    for (int i = N - 1; i >= 3; i--) if (m[i]) return 1 << i;
    return 0;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) lens[i] = '0;
    idle(3);
    chk("R1 grant zero in reset", int'(grant), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant zero after reset", int'(grant), 0);

    for (int m = 1; m < (1 << N); m++) do_req("R1 identity strict order", m, lowest(m));

    for (int s = 3; s < N; s++) wr(0, s, 11 - s);
    wr(0, 0, 8);
    for (int m = 1; m < (1 << N); m++) do_req("R3 reversed slot order", m, rev_exp(m));
    do_req("R4 slot 0 write ignored", 9'h102, 9'h002);

    req = 9'h108;
    @(negedge clk);
    chk("R9 grant before dropped write", int'(grant), 9'h100);
    cfg_we = 1'b1; cfg_kind = 3'd0; cfg_idx = 4'd3; cfg_data = 16'd3; req = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    do_req("R9 write during grant discarded", 9'h108, 9'h100);
    for (int s = 3; s < N; s++) wr(0, s, s);
    do_req("R9 write between grants applied", 9'h108, 9'h008);
    wr(0, 4, 12);
    do_req("R9 out-of-range slot write ignored", 9'h030, 9'h010);

    wr(1, 0, 0);
    wr(2, 0, 9'h1F8);
    do_req("R4 client 0 stays strict", 9'h001, 9'h001);
    do_req("R4 client 2 stays strict", 9'h004, 9'h004);

    wr(1, 0, 9'h00F);
    wr(2, 0, 9'h1F0);
    wr(0, 3, 8);
    wr(0, 8, 3);
    do_req("R5 strict beats weighted in lower slot", 9'h108, 9'h008);
    wr(0, 3, 3);
    wr(0, 8, 8);
    do_req("R6 weighted tie lowest slot", 9'h030, 9'h010);
    do_req("R6 weighted tie lowest slot b", 9'h0A0, 9'h020);
    wr(2, 0, 9'h1B0);
    do_req("R6 neither strict nor weighted never granted", 9'h040, 0);
    wr(2, 0, 9'h1F0);

    lens[4] = 14'd20;
    wr(4, 4, 5);
    wr(3, 4, 1);
    idle(10);
    do_req("R7 charged client granted", 9'h010, 9'h010);
    do_req("R6 negative credit ineligible", 9'h030, 9'h020);
    idle(30);
    req = 9'h010;
    @(negedge clk);
    chk("R7 first grant of recharge run", int'(grant), 9'h010);
    begin
      int n = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        n++;
        if (grant[4]) break;
      end
      chk("R7 cycles until credit non-negative", n, 16);
    end
    req = '0;
    @(negedge clk);

    lens[7] = 14'd16383;
    wr(3, 7, 4095);
    idle(10);
    req = 9'h080;
    @(negedge clk);
    chk("R10 first grant at reset ceiling", int'(grant), 9'h080);
    begin
      int n = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        n++;
        if (grant[7]) break;
      end
      chk("R10 reset ceiling recovery cycles", n, 3);
    end
    req = '0;
    @(negedge clk);
    wr(3, 7, 0);

    wr(5, 0, 2);
    do_req("R8 burst grant 1", 9'h028, 9'h008);
    do_req("R8 burst grant 2", 9'h028, 9'h008);
    do_req("R8 limit reached weighted served", 9'h028, 9'h020);
    do_req("R8 run restarts", 9'h028, 9'h008);
    do_req("R8 second of new run", 9'h008, 9'h008);
    do_req("R8 held strict alone gets nothing", 9'h008, 0);
    do_req("R8 empty decision clears run", 9'h008, 9'h008);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule